// File: doc/BRIEF.md
# LCD Panel Timing and Refresh Engine

This block drives a 320x240 monochrome LCD panel that holds no image of its own, so every frame has to be streamed to it without pause. From a single 10.24 MHz system clock it derives a 1.28 MHz shift clock, a line pulse and a frame pulse. It moves pixel data to the panel four bits at a time. The data comes from two small on-chip word buffers that work as a ping-pong pair.

The panel side unloads one buffer. It sends each 16-bit word as four nibbles, most significant nibble first. During that time a host-side fetch engine fills the other buffer through a simple write port and then marks it full. After 128 shift periods (32 words, about 100 us) the buffers trade roles, and the block pulses a refill request for the bank it has just drained. If the incoming bank was never marked full, the block latches an underrun flag. In that case it freezes the pixel output on its last nibble for the whole of that buffer period instead of sending stale contents.

Top module: `lcd_refresh_engine`

## Requirements
- R1: `shift_clk` has a period of 8 system clocks, with 4 cycles high followed by 4 cycles low. It is low during reset, and its first rising edge follows the 4th rising system clock edge after reset is released.
- R2: `pix_data` changes only at the system clock edge where `shift_clk` rises. Within a buffer it presents words in address order 0 to 31, and bits [15:12] of each word come first, then [11:8], [7:4] and [3:0].
- R3: Shift periods are numbered from 0 after reset. `line_pulse` is high for the whole of every shift period whose number is a multiple of 80, and low in all other shift periods.
- R4: `frame_pulse` is high for the whole of every shift period whose number is a multiple of 19200 (240 lines). It is only ever high together with `line_pulse`.
- R5: The buffers swap after every 128 shift periods. `refill_req` is high for exactly one system cycle, the cycle that starts with the rising `shift_clk` of period 128n+127. In that same cycle `wr_bank` toggles.
- R6: Writes with `wr_en` go to the bank given by `wr_bank`, at `wr_addr`. A one-cycle `fill_done` marks that bank full. Writes never change the nibbles of the bank being shown.
- R7: At a swap, the incoming bank may not be marked full. In that case `underrun` goes high in the swap cycle and stays high until reset, and `pix_data` holds its last value for the whole next 128-period buffer. A bank's full mark is cleared when it is drained, so its old contents are never shown again.
- R8: After reset, bank 0 is on the panel side and `wr_bank` is 1. The first buffer period outputs nibble 0 and does not raise `underrun`.
- R9: Synchronous active-high reset drives `shift_clk`, `line_pulse`, `frame_pulse`, `refill_req` and `underrun` low, and `pix_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10.24 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe into the write-side bank |
| wr_addr | input | 5 | Word address of the host write |
| wr_data | input | 16 | Word written by the host |
| fill_done | input | 1 | One-cycle mark that the write-side bank is full |
| wr_bank | output | 1 | Bank that the host should fill now |
| refill_req | output | 1 | One-cycle request issued at each swap |
| underrun | output | 1 | Sticky flag: a swap found the incoming bank not full |
| shift_clk | output | 1 | Panel shift clock, system clock / 8 |
| line_pulse | output | 1 | Panel line latch pulse |
| frame_pulse | output | 1 | Panel first-line marker |
| pix_data | output | 4 | Panel pixel nibble |

## Verification
Some properties are checked in every cycle. The pixel nibble, line and frame marks move only at a shift-clock rise. The frame mark never appears without the line mark. The refill request lasts one cycle and flips the write bank. The underrun flag never clears outside reset, and a starved buffer period keeps the output frozen. The bench scenarios are needed for the rest: the exact 4-high/4-low shape, nibble order and word order against written patterns, the 80- and 19200-period spacing across a full frame, the hold value after a real underrun, and that a drained bank's stale data is never reused.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int SYS_PER_SHIFT = 8;
    localparam int BUF_WORDS     = 32;
    localparam int WORD_W        = 16;
    localparam int NIB_W         = 4;
    localparam int LINE_SHIFTS   = 80;
    localparam int FRAME_LINES   = 240;

    // Scan marks emitted once per shift period.
    typedef struct packed {
        logic line;
        logic frame;
    } scan_mark_t;

    // Right-shift amount that brings nibble 'nib' (0 = most significant) to the bottom.
    function automatic int unsigned nib_shift(input int unsigned nib,
                                              input int unsigned nibs_per_word,
                                              input int unsigned nib_w);
        return (nibs_per_word - 1 - nib) * nib_w;
    endfunction

endpackage

// File: rtl/lcd_clk_div.sv
module lcd_clk_div #(
    parameter int DIV = lcd_pkg::SYS_PER_SHIFT
) (
    input  logic clk,
    input  logic rst,
    output logic shift_clk,
    output logic step
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] phase;
    logic [CW-1:0] phase_nx;

    always_comb begin
        phase_nx = (phase == CW'(DIV - 1)) ? '0 : phase + 1'b1;
        step     = (phase == CW'(HALF - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= '0;
            shift_clk <= 1'b0;
        end else begin
            phase     <= phase_nx;
            shift_clk <= (phase_nx >= CW'(HALF));
        end
    end

    AST_SCLK_RISE_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> $rose(shift_clk)); // R1
    AST_SCLK_RISE_ONLY_STEP: assert property (@(posedge clk) disable iff (rst)
        !step |=> !$rose(shift_clk)); // R1

endmodule

// File: rtl/lcd_scan_ctr.sv
module lcd_scan_ctr #(
    parameter int LINE_LEN  = lcd_pkg::LINE_SHIFTS,
    parameter int FRAME_LEN = lcd_pkg::FRAME_LINES
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic line_pulse,
    output logic frame_pulse
);
    import lcd_pkg::*;

    localparam int COL_W = $clog2(LINE_LEN);
    localparam int ROW_W = $clog2(FRAME_LEN);

    logic [COL_W-1:0] col_nx;
    logic [ROW_W-1:0] row_nx;
    scan_mark_t       mark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_nx <= '0;
            row_nx <= '0;
            mark_q <= '0;
        end else if (step) begin
            mark_q.line  <= (col_nx == '0);
            mark_q.frame <= (col_nx == '0) && (row_nx == '0);
            if (col_nx == COL_W'(LINE_LEN - 1)) begin
                col_nx <= '0;
                row_nx <= (row_nx == ROW_W'(FRAME_LEN - 1)) ? '0 : row_nx + 1'b1;
            end else begin
                col_nx <= col_nx + 1'b1;
            end
        end
    end

    assign line_pulse  = mark_q.line;
    assign frame_pulse = mark_q.frame;

    AST_MARKS_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(mark_q)); // R3
    AST_FRAME_WITH_LINE: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |-> line_pulse); // R4

endmodule

// File: rtl/lcd_pingpong.sv
module lcd_pingpong #(
    parameter int WORDS  = lcd_pkg::BUF_WORDS,
    parameter int WORD_W = lcd_pkg::WORD_W,
    parameter int NIB_W  = lcd_pkg::NIB_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     fill_done,
    output logic                     wr_bank,
    output logic                     refill_req,
    output logic                     underrun,
    output logic [NIB_W-1:0]         pix_data
);
    import lcd_pkg::*;

    localparam int NPW       = WORD_W / NIB_W;
    localparam int NIB_IDX_W = (NPW > 1) ? $clog2(NPW) : 1;
    localparam int POS_W     = $clog2(WORDS * NPW);
    localparam int AW        = $clog2(WORDS);

    logic              active;
    logic [POS_W-1:0]  pos;
    logic [1:0]        full;
    logic              starved;
    logic [AW-1:0]     word_idx;
    logic [NIB_IDX_W-1:0] nib_idx;
    logic              last_pos;
    logic              incoming_full;
    logic [WORD_W-1:0] rd_word [2];
    logic [WORD_W-1:0] shifted;

    assign word_idx = pos[POS_W-1 -: AW];
    assign nib_idx  = pos[NIB_IDX_W-1:0];
    assign last_pos = (pos == POS_W'(WORDS * NPW - 1));
    assign wr_bank  = ~active;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [WORD_W-1:0] store [WORDS];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b)))
                store[wr_addr] <= wr_data;
        end
        assign rd_word[b] = store[word_idx];
    end

    always_comb begin
        incoming_full = full[~active] | fill_done;
        shifted = rd_word[active] >> nib_shift(32'(nib_idx), NPW, NIB_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            pos        <= '0;
            full       <= '0;
            starved    <= 1'b1;
            underrun   <= 1'b0;
            pix_data   <= '0;
            refill_req <= 1'b0;
        end else begin
            refill_req <= 1'b0;
            if (fill_done)
                full[~active] <= 1'b1;
            if (step) begin
                if (!starved)
                    pix_data <= shifted[NIB_W-1:0];
                pos <= pos + 1'b1;
                if (last_pos) begin
                    active       <= ~active;
                    refill_req   <= 1'b1;
                    full[active] <= 1'b0;
                    starved      <= ~incoming_full;
                    if (!incoming_full)
                        underrun <= 1'b1;
                end
            end
        end
    end

    AST_PIX_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pix_data)); // R2
    AST_REFILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        refill_req |=> !refill_req); // R5
    AST_BANK_FLIPS_ON_REFILL: assert property (@(posedge clk) disable iff (rst)
        refill_req |-> (wr_bank != $past(wr_bank))); // R5
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun); // R7
    AST_STARVED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step && starved) |=> $stable(pix_data)); // R7

endmodule

// File: rtl/lcd_refresh_engine.sv
module lcd_refresh_engine #(
    parameter int DIV       = lcd_pkg::SYS_PER_SHIFT,
    parameter int WORDS     = lcd_pkg::BUF_WORDS,
    parameter int WORD_W    = lcd_pkg::WORD_W,
    parameter int NIB_W     = lcd_pkg::NIB_W,
    parameter int LINE_LEN  = lcd_pkg::LINE_SHIFTS,
    parameter int FRAME_LEN = lcd_pkg::FRAME_LINES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     fill_done,
    output logic                     wr_bank,
    output logic                     refill_req,
    output logic                     underrun,
    output logic                     shift_clk,
    output logic                     line_pulse,
    output logic                     frame_pulse,
    output logic [NIB_W-1:0]         pix_data
);
    logic step;

    lcd_clk_div #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .shift_clk (shift_clk),
        .step      (step)
    );

    lcd_scan_ctr #(.LINE_LEN(LINE_LEN), .FRAME_LEN(FRAME_LEN)) u_scan (
        .clk         (clk),
        .rst         (rst),
        .step        (step),
        .line_pulse  (line_pulse),
        .frame_pulse (frame_pulse)
    );

    lcd_pingpong #(.WORDS(WORDS), .WORD_W(WORD_W), .NIB_W(NIB_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fill_done  (fill_done),
        .wr_bank    (wr_bank),
        .refill_req (refill_req),
        .underrun   (underrun),
        .pix_data   (pix_data)
    );

    AST_REFILL_AT_SCLK_RISE: assert property (@(posedge clk) disable iff (rst)
        refill_req |-> $rose(shift_clk)); // R5

endmodule

// File: tb/sim_lcd_refresh_engine.sv
module sim_lcd_refresh_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        fill_done = 1'b0;
    logic        wr_bank, refill_req, underrun, shift_clk, line_pulse, frame_pulse;
    logic [3:0]  pix_data;

    always #4 clk = ~clk;

    lcd_refresh_engine u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fill_done(fill_done), .wr_bank(wr_bank), .refill_req(refill_req),
        .underrun(underrun), .shift_clk(shift_clk), .line_pulse(line_pulse),
        .frame_pulse(frame_pulse), .pix_data(pix_data)
    );

    // Stimulus vectors: base words, combined with index and buffer number.
    localparam logic [15:0] PAT [8] = '{16'h1234, 16'hABCD, 16'h0000, 16'hFFFF,
                                        16'h8421, 16'h5A5A, 16'hC3E7, 16'h0F0F};

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    function automatic logic [15:0] pat_word(input int k, input int i);
        return PAT[i % 8] + 16'(i) + 16'(k * 256);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor: sampled on the falling system clock edge.
    int s = -1;
    int run = 0;
    int edges = 0;
    int swaps = 0;
    bit prev_sclk = 0;
    bit prev_refill = 0;
    logic [3:0] last_exp = '0;

    always @(negedge clk) begin
        if (rst) begin
            s = -1; run = 0; edges = 0; swaps = 0;
            prev_sclk = 0; prev_refill = 0; last_exp = '0;
        end else begin
            if (shift_clk != prev_sclk) begin
                if (edges > 0) chk(run == 4, "R1 half-period", run, 4);
                edges++;
                run = 1;
            end else begin
                run++;
            end
            if (shift_clk && !prev_sclk) begin
                int n, i, k;
                logic [3:0] e;
                string req;
                s++;
                n = s / 128; i = s % 128;
                k = (n == 1) ? 1 : (n == 2) ? 2 : (n == 4) ? 3 : 0;
                if (k != 0) begin
                    e = 4'(pat_word(k, i / 4) >> ((3 - i % 4) * 4));
                    last_exp = e;
                    req = "R2 nibble";
                end else begin
                    e = last_exp;
                    req = (n == 0) ? "R8 first buffer" : "R7 hold";
                end
                chk(pix_data == e, req, pix_data, e);
                chk(line_pulse == (s % 80 == 0), "R3 line", line_pulse, s % 80 == 0);
                chk(frame_pulse == (s % 19200 == 0), "R4 frame", frame_pulse, s % 19200 == 0);
                if (s < 640) chk(underrun == (s >= 383), "R7 underrun", underrun, s >= 383);
                if (s < 383) chk(!underrun, "R8 no early underrun", underrun, 0);
            end
            if (refill_req) begin
                swaps++;
                chk(s % 128 == 127, "R5 refill position", s % 128, 127);
                chk(!prev_refill, "R5 refill width", prev_refill, 0);
                chk(wr_bank == ~swaps[0], "R5 bank toggle", wr_bank, ~swaps[0]);
            end
            prev_sclk = shift_clk;
            prev_refill = refill_req;
        end
    end

    task automatic fill(input int k);
        for (int i = 0; i < 32; i++) begin
            wr_en = 1'b1; wr_addr = 5'(i); wr_data = pat_word(k, i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        fill_done = 1'b1;
        @(negedge clk);
        fill_done = 1'b0;
    endtask

    task automatic wait_refill();
        do @(negedge clk); while (!refill_req);
    endtask

    task automatic check_reset_state(input string tag);
        chk(shift_clk == 0, {tag, " R9 shift_clk"}, shift_clk, 0);
        chk(line_pulse == 0, {tag, " R9 line"}, line_pulse, 0);
        chk(frame_pulse == 0, {tag, " R9 frame"}, frame_pulse, 0);
        chk(refill_req == 0, {tag, " R9 refill"}, refill_req, 0);
        chk(underrun == 0, {tag, " R9 underrun"}, underrun, 0);
        chk(pix_data == 0, {tag, " R9 pix"}, pix_data, 0);
        chk(wr_bank == 1, {tag, " R8 wr_bank"}, wr_bank, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check_reset_state("initial");
        rst = 1'b0;
        // R6: host fills bank 1 while bank 0 is unloaded (starved start).
        chk(wr_bank == 1, "R6 first write bank", wr_bank, 1);
        fill(1);
        wait_refill();
        chk(wr_bank == 0, "R6 second write bank", wr_bank, 0);
        fill(2);
        wait_refill();
        // R7: leave bank 1 unfilled so the next swap underruns.
        wait_refill();
        chk(wr_bank == 0, "R7 write bank after underrun", wr_bank, 0);
        fill(3);
        // Run past the second frame pulse (R4).
        while (s < 19201) @(negedge clk);
        chk(s == 19201, "R4 frame span reached", s, 19201);
        // Directed: mid-run reset clears everything (R9).
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state("midrun");
        rst = 1'b0;
        // R1: first rise after the 4th edge following release.
        repeat (3) @(negedge clk);
        chk(shift_clk == 0, "R1 still low after 3 edges", shift_clk, 0);
        @(negedge clk);
        chk(shift_clk == 1, "R1 high after 4 edges", shift_clk, 1);
        chk(line_pulse && frame_pulse, "R4 marks after reset", {line_pulse, frame_pulse}, 3);
        repeat (200) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", s, 19201);
        finish_run();
    end

endmodule